// File: doc/BRIEF.md
# Sync Clock Selector with Fallback

This block chooses the timing source for a two-phase push-pull gate driver. By default it steps its two gate phases from a one-cycle tick produced by an internal oscillator. It also watches an external clock input that has no timing relation to the system clock. When that input shows a steady run of rising edges, the block hands the phases over to it. In that mode each external rising edge moves the drive to the other phase, so each gate runs at half the external frequency. If the external edges stop, the block falls back to the oscillator tick. It takes the external clock again as soon as a fresh run of edges appears.

Any change of source happens at a phase boundary. Both gates are held low through a handover slot, so the two phases never overlap and no shortened pulse occurs. While the external source drives the phases, the duty-cycle and spread-spectrum enables are forced low. In internal mode they follow their request inputs. A sync flag shows which source is in use.

Top module: `sync_clk_sel`

## Requirements
- R1: After reset, gate_a, gate_b and sync_mode are low, and the block is in internal mode.
- R2: In internal mode, each osc_tick pulse moves the drive to the other phase. The first tick after reset or after a handover raises gate_a, then gate_b and gate_a take turns. N ticks from reset give ceil(N/2) gate_a pulses and floor(N/2) gate_b pulses.
- R3: Sync mode is entered only after ENTRY_EDGES (default 5) synchronized rising edges of ext_clk, each arriving less than TIMEOUT system cycles after the one before. A longer gap restarts the count. After the run, the switch takes place at the next osc_tick.
- R4: In sync mode, each synchronized ext_clk rising edge moves the drive to the other phase, so gate_a pulses once per two external periods. osc_tick has no effect in this mode.
- R5: In sync mode, if no ext_clk rising edge is seen for TIMEOUT system cycles, sync_mode drops and the block returns to internal mode.
- R6: An ext_clk that stays high from power-up (floating high), or stays at one level, never causes sync mode. The synchronizer resets to the high level, so a high input gives no edge.
- R7: gate_a and gate_b are never high at the same time.
- R8: In every cycle where sync_mode changes, both gates are low. They stay low until the first event of the new source.
- R9: dc_en follows dc_req and ss_en follows ss_req only in internal mode. Both are low while sync_mode is high or a handover is in progress.
- R10: After a fall-back to internal mode, a new qualifying run of ext_clk edges brings the block back into sync mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse from the internal oscillator, one per phase step |
| ext_clk | input | 1 | Asynchronous external sync clock |
| dc_req | input | 1 | Duty-cycle control request |
| ss_req | input | 1 | Spread-spectrum modulation request |
| gate_a | output | 1 | Gate drive, phase A |
| gate_b | output | 1 | Gate drive, phase B |
| sync_mode | output | 1 | High while the phases follow ext_clk |
| dc_en | output | 1 | Duty-cycle control enable |
| ss_en | output | 1 | Spread-spectrum modulation enable |

## Verification
The bench drives the phases from a fixed tick train. The tick period is deliberately far from the external period, so phase counts taken in sync mode show which source is actually in control. A steady-high input and a steady-low input test that levels alone never qualify. Four-edge bursts split by long gaps test that the edge count restarts, and an exact five-edge burst tests the entry point. Random burst lengths and edge spacings, from a fixed seed, are compared against the expected entry decision. A final stopped clock measures the timeout from both sides, and a later burst checks that the block takes the external clock again.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;

    typedef enum logic [1:0] {
        SRC_INT    = 2'd0,
        SRC_TO_EXT = 2'd1,
        SRC_EXT    = 2'd2,
        SRC_TO_INT = 2'd3
    } src_state_e;

    typedef struct packed {
        logic a;
        logic b;
    } gate_pair_t;

    localparam gate_pair_t GATES_OFF = '{a: 1'b0, b: 1'b0};

    // Next phase: from idle start on A, otherwise swap the active phase.
    function automatic gate_pair_t next_phase(input gate_pair_t cur);
        gate_pair_t nxt;
        if (!cur.a && !cur.b) begin
            nxt = '{a: 1'b1, b: 1'b0};
        end else begin
            nxt = '{a: cur.b, b: cur.a};
        end
        return nxt;
    endfunction

endpackage

// File: rtl/ext_rise_det.sv
module ext_rise_det #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous value
    logic [STAGES:0] chain;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("ext_rise_det needs at least two stages");
        end
    endgenerate

    // Reset to high: a floating-high input then shows no rising edge (R6)
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/ext_lock_det.sv
module ext_lock_det #(
    parameter int unsigned TIMEOUT     = 64,
    parameter int unsigned ENTRY_EDGES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    output logic ext_ok,
    output logic ext_lost
);
    localparam int unsigned TW = $clog2(TIMEOUT + 1);
    localparam int unsigned EW = $clog2(ENTRY_EDGES + 1);
    localparam logic [TW-1:0] T_LOAD = TW'(TIMEOUT);
    localparam logic [EW-1:0] E_FULL = EW'(ENTRY_EDGES);

    logic [TW-1:0] gap_tmr;
    logic [EW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_tmr <= '0;
            run_cnt <= '0;
        end else if (rise) begin
            gap_tmr <= T_LOAD;
            if (gap_tmr == '0) begin
                run_cnt <= EW'(1);
            end else if (run_cnt != E_FULL) begin
                run_cnt <= run_cnt + EW'(1);
            end
        end else if (gap_tmr != '0) begin
            gap_tmr <= gap_tmr - TW'(1);
        end else begin
            run_cnt <= '0;
        end
    end

    assign ext_ok   = (run_cnt == E_FULL);
    assign ext_lost = (gap_tmr == '0);

    // R3: qualification can only appear right after a counted edge
    a_r3_ok_after_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_ok) |-> $past(rise));

endmodule

// File: rtl/phase_seq.sv
module phase_seq
    import sync_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       ext_rise,
    input  logic       ext_ok,
    input  logic       ext_lost,
    output gate_pair_t gates,
    output src_state_e state
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SRC_INT;
            gates <= GATES_OFF;
        end else begin
            case (state)
                SRC_INT: begin
                    if (tick) begin
                        if (ext_ok) begin
                            state <= SRC_TO_EXT;
                            gates <= GATES_OFF;
                        end else begin
                            gates <= next_phase(gates);
                        end
                    end
                end
                SRC_TO_EXT: state <= SRC_EXT;
                SRC_EXT: begin
                    if (ext_lost && !ext_rise) begin
                        state <= SRC_TO_INT;
                        gates <= GATES_OFF;
                    end else if (ext_rise) begin
                        gates <= next_phase(gates);
                    end
                end
                default: state <= SRC_INT;
            endcase
        end
    end

    // R7: phases never overlap
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gates.a, gates.b}));

    // R8: both phases low whenever the external mode is entered or left
    a_r8_switch_low: assert property (@(posedge clk) disable iff (rst)
        ((state == SRC_EXT) != $past(state == SRC_EXT)) |-> (gates == GATES_OFF));

    // R4: in external mode the phases hold unless an external edge arrived
    a_r4_tick_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == SRC_EXT && $past(state) == SRC_EXT && !$past(ext_rise))
            |-> $stable(gates));

endmodule

// File: rtl/sync_clk_sel.sv
module sync_clk_sel
    import sync_sel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TIMEOUT     = 64,
    parameter int unsigned ENTRY_EDGES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic osc_tick,
    input  logic ext_clk,
    input  logic dc_req,
    input  logic ss_req,
    output logic gate_a,
    output logic gate_b,
    output logic sync_mode,
    output logic dc_en,
    output logic ss_en
);
    logic       ext_rise;
    logic       ext_ok;
    logic       ext_lost;
    gate_pair_t gates;
    src_state_e state;

    ext_rise_det #(.STAGES(SYNC_STAGES)) u_rise (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_clk),
        .rise     (ext_rise)
    );

    ext_lock_det #(.TIMEOUT(TIMEOUT), .ENTRY_EDGES(ENTRY_EDGES)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .rise     (ext_rise),
        .ext_ok   (ext_ok),
        .ext_lost (ext_lost)
    );

    phase_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (osc_tick),
        .ext_rise (ext_rise),
        .ext_ok   (ext_ok),
        .ext_lost (ext_lost),
        .gates    (gates),
        .state    (state)
    );

    assign gate_a    = gates.a;
    assign gate_b    = gates.b;
    assign sync_mode = (state == SRC_EXT);
    assign dc_en     = dc_req && (state == SRC_INT);
    assign ss_en     = ss_req && (state == SRC_INT);

    // R1: outputs idle in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (!gate_a && !gate_b && !sync_mode));

    // R9: modulation features off while following the external clock
    a_r9_features_off: assert property (@(posedge clk) disable iff (rst)
        sync_mode |-> (!dc_en && !ss_en));

    // R5: a silent external clock ends sync mode on the next cycle
    a_r5_timeout_exit: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && ext_lost && !ext_rise) |=> !sync_mode);

endmodule

// File: tb/test_sync_clk_sel.sv
module test_sync_clk_sel;
    localparam int TO       = 64;
    localparam int TICK_PER = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_tick = 1'b0;
    logic ext_clk = 1'b1;
    logic dc_req = 1'b1;
    logic ss_req = 1'b1;
    logic gate_a, gate_b, sync_mode, dc_en, ss_en;

    always #2 clk = ~clk;

    sync_clk_sel #(.SYNC_STAGES(2), .TIMEOUT(TO), .ENTRY_EDGES(5)) i_sync_clk_sel (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .ext_clk   (ext_clk),
        .dc_req    (dc_req),
        .ss_req    (ss_req),
        .gate_a    (gate_a),
        .gate_b    (gate_b),
        .sync_mode (sync_mode),
        .dc_en     (dc_en),
        .ss_en     (ss_en)
    );

    int total  = 0;
    int failed = 0;

    // tick source: one pulse every TICK_PER cycles while under the limit
    int tick_limit = 0;
    int issued     = 0;
    int tick_ph    = 0;
    always @(negedge clk) begin
        osc_tick <= 1'b0;
        if (!rst && issued < tick_limit) begin
            tick_ph = tick_ph + 1;
            if (tick_ph == TICK_PER) begin
                tick_ph = 0;
                osc_tick <= 1'b1;
                issued = issued + 1;
            end
        end
    end

    // ext rising edges, sampled while ext_clk is stable
    int   ext_total = 0;
    logic ext_prev  = 1'b1;
    always @(posedge clk) begin
        if (ext_clk && !ext_prev) ext_total = ext_total + 1;
        ext_prev = ext_clk;
    end

    // output monitor
    int   cnt_a = 0, cnt_b = 0, overlap = 0, switch_bad = 0, sync_rises = 0;
    int   a_base = 0, e_base = 0;
    logic pa = 1'b0, pb = 1'b0, ps = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (gate_a && gate_b) overlap = overlap + 1;
            if (sync_mode != ps && (gate_a || gate_b)) switch_bad = switch_bad + 1;
            if (gate_a && !pa) cnt_a = cnt_a + 1;
            if (gate_b && !pb) cnt_b = cnt_b + 1;
            if (sync_mode && !ps) begin
                sync_rises = sync_rises + 1;
                a_base = cnt_a;
                e_base = ext_total;
            end
        end
        pa = gate_a;
        pb = gate_b;
        ps = sync_mode;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            failed = failed + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_edges(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1;
            idle(half);
            ext_clk = 1'b0;
            idle(half);
        end
    endtask

    function automatic int exp_entries(input int edges);
        return (edges >= 5) ? 1 : 0;
    endfunction

    function automatic int abs_i(input int v);
        return (v < 0) ? -v : v;
    endfunction

    bit done = 1'b0;

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total = total + 1;
            failed = failed + 1;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end

    initial begin
        int s0, n, half, se, sa;
        void'($urandom(32'd20240611));
        idle(5);
        rst = 1'b0;
        idle(2);
        // R1 reset state
        check(!gate_a && !gate_b, "R1", "gates after reset", {gate_a, gate_b}, 0);
        check(!sync_mode, "R1", "sync flag after reset", sync_mode, 0);
        check(dc_en && ss_en, "R9", "enables follow requests", {dc_en, ss_en}, 3);

        // R2 internal stepping: 40 ticks from idle
        tick_limit = 40;
        idle(40 * TICK_PER + 6);
        check(cnt_a == 20, "R2", "gate_a pulses", cnt_a, 20);
        check(cnt_b == 20, "R2", "gate_b pulses", cnt_b, 20);

        // R6 ext held high since power-up, then low, with ticks running
        tick_limit = 1000000;
        idle(200);
        check(sync_rises == 0, "R6", "entries with ext high", sync_rises, 0);
        ext_clk = 1'b0;
        idle(TO + 200);
        check(sync_rises == 0, "R6", "entries with ext low", sync_rises, 0);

        // R9 request low in internal mode
        dc_req = 1'b0;
        idle(2);
        check(!dc_en && ss_en, "R9", "dc_en tracks dc_req", {dc_en, ss_en}, 1);
        dc_req = 1'b1;

        // R3 partial runs split by gaps longer than the timeout
        ext_edges(4, 5);
        idle(TO + 40);
        ext_edges(4, 5);
        idle(TO + 40);
        check(sync_rises == 0, "R3", "entries from split runs", sync_rises, 0);

        // R3 exactly five edges
        s0 = sync_rises;
        ext_edges(5, 5);
        idle(20);
        check(sync_rises - s0 == 1, "R3", "entry after five edges", sync_rises - s0, 1);
        idle(TO + 20);
        check(!sync_mode, "R5", "exit after short burst", sync_mode, 0);

        // R4 continuous external clock, period far from tick period
        ext_edges(50, 9);
        check(sync_mode, "R4", "in sync during long run", sync_mode, 1);
        check(!dc_en && !ss_en, "R9", "enables off in sync", {dc_en, ss_en}, 0);
        se = ext_total - e_base;
        sa = cnt_a - a_base;
        check(abs_i(2 * sa - se) <= 2, "R4", "gate_a pulses x2 vs ext edges", 2 * sa, se);

        // R5 timeout boundaries: last rise was 18 cycles ago
        idle(TO - 30);
        check(sync_mode, "R5", "still in sync before timeout", sync_mode, 1);
        idle(40);
        check(!sync_mode, "R5", "left sync after timeout", sync_mode, 0);
        check(dc_en && ss_en, "R9", "enables restored", {dc_en, ss_en}, 3);

        // R10 re-acquire
        s0 = sync_rises;
        ext_edges(10, 4);
        check(sync_mode, "R10", "back in sync", sync_mode, 1);
        check(sync_rises - s0 == 1, "R10", "one re-entry", sync_rises - s0, 1);
        idle(TO + 40);

        // R3 random burst lengths and spacings
        for (int r = 0; r < 14; r++) begin
            n = 1 + int'($urandom % 8);
            half = 3 + int'($urandom % 8);
            s0 = sync_rises;
            ext_edges(n, half);
            idle(TO + 40);
            check(sync_rises - s0 == exp_entries(n), "R3", "random burst entry",
                  sync_rises - s0, exp_entries(n));
            check(!sync_mode, "R5", "random burst exit", sync_mode, 0);
        end

        check(overlap == 0, "R7", "cycles with both gates high", overlap, 0);
        check(switch_bad == 0, "R8", "switches with a gate high", switch_bad, 0);
        done = 1'b1;
        finish_run();
    end

endmodule